// File: doc/BRIEF.md
# Saturating Clear-on-Read Performance Counter Bank

This block keeps three 8-bit error and event counters for a framed line receiver. A single mode input decides what the first two counters accumulate. With the mode input low (C-bit parity operation), the first counter tallies far-end block errors and the second tallies C-bit parity errors. A far-end block error is a frame whose three received block-error C-bits are not all one. With the mode input high (M13 operation), the first counter tallies framing/multiframe bit errors and the second tallies received frames. The third counter tallies P-bit parity errors in both modes. The parity errors are detected upstream and reach the block as single-cycle pulses.

A host reads a counter by pulsing a read strobe with an address. The value appears on the data output one cycle later, and the counter is cleared in the same cycle. Each counter stops at its maximum value and never wraps. No event is counted while loss of signal or out-of-frame is asserted. An event that arrives while its counter is being read, or while an internal update cycle is flagged, is parked in a one-deep holding flag. The held event is added once the window closes, so at most one such event survives the window.

Top module: `perf_counter_bank`

## Requirements
- R1: A counter that holds 2^CNT_W-1 (255 by default) stays at that value for any further events until it is read.
- R2: A read strobe with address 0, 1 or 2 places that counter's current value on rd_data after the next clock edge and clears the counter at that edge. Address 3 returns zero and clears nothing. rd_data keeps its value between reads.
- R3: A qualified event that arrives while its counter is being read, or while int_upd is high, is not lost. It is added to the counter in the first cycle after the window closes, so a counter read as zero shows 1 at its next read.
- R4: However many qualified events arrive during one read or int_upd window, only one is held and added afterwards.
- R5: While los or oof is high, no incoming event changes any counter. This covers frame pulses in M13 mode.
- R6: With mode_m13 low, counter 0 increments on each cycle with frame_stb high and any of cbit_a, cbit_b, cbit_c low. It ignores fm_err_stb.
- R7: With mode_m13 high, counter 0 increments on fm_err_stb and counter 1 increments on frame_stb. Both ignore the C-bits and cpar_err_stb.
- R8: With mode_m13 low, counter 1 increments on cpar_err_stb. In both modes, counter 2 increments on ppar_err_stb.
- R9: After a synchronous active-low reset, all counters are zero, no event is held and rd_data is zero.
- R10: In the cycle after a window closes, a held event and a fresh event are both added, giving a step of two, still limited by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_m13 | input | 1 | 1 = M13 operation, 0 = C-bit parity operation |
| los | input | 1 | Loss of signal, inhibits counting |
| oof | input | 1 | Out of frame, inhibits counting |
| frame_stb | input | 1 | One pulse per received frame; C-bits valid with it |
| cbit_a | input | 1 | First far-end block error C-bit |
| cbit_b | input | 1 | Second far-end block error C-bit |
| cbit_c | input | 1 | Third far-end block error C-bit |
| fm_err_stb | input | 1 | Framing/multiframe bit error pulse |
| cpar_err_stb | input | 1 | C-bit parity error pulse |
| ppar_err_stb | input | 1 | P-bit parity error pulse |
| int_upd | input | 1 | Internal update cycle; all counters hold and park events |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | 2 | Counter select for a read |
| rd_data | output | CNT_W | Registered read data |

## Verification
The bench uses the default CNT_W of 8. At that width, a run of 300 P-bit pulses with no reads in between drives a counter past 255, so the saturation limit is reached in a directed case. It is also reached by chance whenever random reads are sparse. Keeping the width small keeps the clear-then-add-one sequence, the two-step increment after a window and the address-3 read all within a few cycles of each other. Random traffic mixes both modes, los/oof and int_upd windows.

// File: rtl/pcb_pkg.sv
// Package: shared constants for the performance counter bank.
// Assumes three counters selected by a two-bit address.
package pcb_pkg;
    localparam int NUM_CTR = 3;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_BLK  = 2'd0,   // far-end block error / F&M bit error
        SEL_CBF  = 2'd1,   // C-bit parity error / frame count
        SEL_PPAR = 2'd2,   // P-bit parity error
        SEL_NONE = 2'd3    // unused, reads zero
    } ctr_sel_e;
endpackage

// File: rtl/pcb_event_route.sv
// Module: picks the event that feeds each counter according to the mode.
// Assumes C-bits are valid in the cycle frame_stb is high.
module pcb_event_route
    import pcb_pkg::*;
(
    input  logic               mode_m13,
    input  logic               frame_stb,
    input  logic               cbit_a,
    input  logic               cbit_b,
    input  logic               cbit_c,
    input  logic               fm_err_stb,
    input  logic               cpar_err_stb,
    input  logic               ppar_err_stb,
    output logic [NUM_CTR-1:0] evt
);
    logic febe;

    // Decode a far-end block error: any C-bit of the frame received as zero.
    always_comb febe = frame_stb & ~(cbit_a & cbit_b & cbit_c);

    // Route events to counters by operating mode.
    always_comb begin
        evt           = '0;
        evt[SEL_BLK]  = mode_m13 ? fm_err_stb : febe;
        evt[SEL_CBF]  = mode_m13 ? frame_stb  : cpar_err_stb;
        evt[SEL_PPAR] = ppar_err_stb;
    end
endmodule

// File: rtl/pcb_sat_counter.sv
// Module: one saturating counter with a one-deep held-event flag.
// Assumes hold is high for any cycle in which clr is high.
module pcb_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             inhibit,
    input  logic             hold,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic             pend;
    logic             evt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] next_sat;

    // Qualify the event with the inhibit condition.
    always_comb evt_q = evt & ~inhibit;

    // Add held and fresh events, clamping at the maximum.
    always_comb begin
        sum      = {1'b0, count} + {{CNT_W{1'b0}}, pend} + {{CNT_W{1'b0}}, evt_q};
        next_sat = (sum > {1'b0, MAXV}) ? MAXV : sum[CNT_W-1:0];
    end

    // Count state: park events during a window, otherwise accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pend  <= 1'b0;
        end else if (hold) begin
            if (evt_q) pend  <= 1'b1;
            if (clr)   count <= '0;
        end else begin
            count <= next_sat;
            pend  <= 1'b0;
        end
    end

    // R1: a full counter does not wrap
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> count == MAXV);
    // R2: a read leaves the counter at zero
    a_r2_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R3: an event inside a window is parked
    a_r3_park_event: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && evt_q) |=> pend);
    // R4: the held flag is consumed once the window closes
    a_r4_single_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && pend) |=> !pend);
    // R5: inhibited events change nothing
    a_r5_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !pend && inhibit) |=> $stable(count));
endmodule

// File: rtl/pcb_read_port.sv
// Module: decodes host reads into clear strobes and registers the read data.
// Assumes counter values are presented as a flat vector, counter 0 lowest.
module pcb_read_port
    import pcb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_stb,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_CTR*CNT_W-1:0] counts,
    output logic [NUM_CTR-1:0]       clr,
    output logic [CNT_W-1:0]         rd_data
);
    logic [CNT_W-1:0] sel_val;

    // One clear strobe per counter, raised when that counter is read.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_clr
        assign clr[i] = rd_stb && (rd_addr == ADDR_W'(i));
    end

    // Select the addressed counter; unused addresses read zero.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_CTR; i++)
            if (rd_addr == ADDR_W'(i)) sel_val = counts[i*CNT_W +: CNT_W];
    end

    // Register read data on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= sel_val;
    end

    // R2: at most one counter cleared per read
    a_r2_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
    // R2: read data holds between strobes
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/perf_counter_bank.sv
// Module: top of the saturating clear-on-read performance counter bank.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_m13,
    input  logic              los,
    input  logic              oof,
    input  logic              frame_stb,
    input  logic              cbit_a,
    input  logic              cbit_b,
    input  logic              cbit_c,
    input  logic              fm_err_stb,
    input  logic              cpar_err_stb,
    input  logic              ppar_err_stb,
    input  logic              int_upd,
    input  logic              rd_stb,
    input  logic [1:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    logic [NUM_CTR-1:0]       evt;
    logic [NUM_CTR-1:0]       clr;
    logic [NUM_CTR*CNT_W-1:0] counts;
    logic                     inhibit;

    // Counting is blocked during loss of signal or loss of frame.
    always_comb inhibit = los | oof;

    pcb_event_route u_route (
        .mode_m13     (mode_m13),
        .frame_stb    (frame_stb),
        .cbit_a       (cbit_a),
        .cbit_b       (cbit_b),
        .cbit_c       (cbit_c),
        .fm_err_stb   (fm_err_stb),
        .cpar_err_stb (cpar_err_stb),
        .ppar_err_stb (ppar_err_stb),
        .evt          (evt)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pcb_sat_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt[i]),
            .inhibit (inhibit),
            .hold    (int_upd | clr[i]),
            .clr     (clr[i]),
            .count   (counts[i*CNT_W +: CNT_W])
        );
    end

    pcb_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .counts  (counts),
        .clr     (clr),
        .rd_data (rd_data)
    );

    // R9: read data is zero in the cycle after reset
    a_r9_reset_data: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);
endmodule

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 0, rst_n = 0;
    logic mode_m13 = 0, los = 0, oof = 0, frame_stb = 0;
    logic cbit_a = 1, cbit_b = 1, cbit_c = 1;
    logic fm_err_stb = 0, cpar_err_stb = 0, ppar_err_stb = 0;
    logic int_upd = 0, rd_stb = 0;
    logic [1:0] rd_addr = 0;
    logic [W-1:0] rd_data;

    int checks = 0, errors = 0;
    int mcnt [3];
    bit mpend [3];
    int exp_rd = 0;

    always #2 clk = ~clk;

    perf_counter_bank #(.CNT_W(W)) u0 (.*);

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    // Which counter an input set feeds, derived from R6, R7, R8.
    function automatic bit ev_of(input int i);
        if (i == 0) return mode_m13 ? fm_err_stb : (frame_stb && !(cbit_a && cbit_b && cbit_c));
        if (i == 1) return mode_m13 ? frame_stb : cpar_err_stb;
        return ppar_err_stb;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: rd_data=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: update the model with the driven inputs, then compare reads.
    task automatic step(input string req);
        bit win, q, was_rd;
        was_rd = rd_stb;
        for (int i = 0; i < 3; i++) begin
            q = ev_of(i) && !(los || oof);
            win = int_upd || (rd_stb && rd_addr == i[1:0]);
            if (win) begin
                if (q) mpend[i] = 1;
                if (rd_stb && rd_addr == i[1:0]) begin exp_rd = mcnt[i]; mcnt[i] = 0; end
            end else begin
                mcnt[i] = sat(mcnt[i] + int'(mpend[i]) + int'(q));
                mpend[i] = 0;
            end
        end
        if (rd_stb && rd_addr == 2'd3) exp_rd = 0;
        @(negedge clk);
        if (was_rd) chk(req, int'(rd_data), exp_rd);
        {frame_stb, fm_err_stb, cpar_err_stb, ppar_err_stb, int_upd, rd_stb} = '0;
        {cbit_a, cbit_b, cbit_c} = 3'b111;
    endtask

    task automatic rd(input int a, input string req);
        rd_stb = 1; rd_addr = a[1:0]; step(req);
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 3; i++) begin mcnt[i] = 0; mpend[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        for (int a = 0; a < 4; a++) rd(a, "R9");
        // R1: saturation on counter 2
        for (int k = 0; k < 300; k++) begin ppar_err_stb = 1; step("R1"); end
        rd(2, "R1"); rd(2, "R1");
        // R3: event during read of counter 2 is held, shows as 1
        ppar_err_stb = 1; rd(2, "R3"); step("R3"); rd(2, "R3");
        // R4: several events during int_upd, only one kept
        for (int k = 0; k < 4; k++) begin int_upd = 1; ppar_err_stb = 1; step("R4"); end
        rd(2, "R4");
        // R10: held plus fresh event after window
        int_upd = 1; cpar_err_stb = 1; step("R10");
        cpar_err_stb = 1; step("R10"); rd(1, "R10");
        // R5: inhibit
        los = 1; ppar_err_stb = 1; step("R5"); los = 0;
        oof = 1; mode_m13 = 1; frame_stb = 1; step("R5"); oof = 0;
        rd(2, "R5"); rd(1, "R5");
        // R6: C-bit mode block errors, fm_err ignored
        mode_m13 = 0;
        frame_stb = 1; cbit_b = 0; step("R6");
        frame_stb = 1; step("R6");
        fm_err_stb = 1; step("R6");
        rd(0, "R6");
        // R7: M13 mode
        mode_m13 = 1;
        fm_err_stb = 1; step("R7");
        frame_stb = 1; cbit_a = 0; cpar_err_stb = 1; step("R7");
        rd(0, "R7"); rd(1, "R7");
        // R8: C-bit parity counter and P-bit counter
        mode_m13 = 0; cpar_err_stb = 1; ppar_err_stb = 1; step("R8");
        rd(1, "R8"); rd(2, "R8");
        // R2: address 3 reads zero, then random traffic
        ppar_err_stb = 1; step("R2"); rd(3, "R2"); rd(2, "R2");
        for (int k = 0; k < 4000; k++) begin
            if ((k % 500) == 0) mode_m13 = $urandom_range(0, 1);
            los = ($urandom_range(0, 19) == 0);
            oof = ($urandom_range(0, 19) == 0);
            frame_stb = $urandom_range(0, 1);
            {cbit_a, cbit_b, cbit_c} = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b111;
            fm_err_stb = $urandom_range(0, 1);
            cpar_err_stb = $urandom_range(0, 1);
            ppar_err_stb = $urandom_range(0, 1);
            int_upd = ($urandom_range(0, 9) == 0);
            rd_stb = ($urandom_range(0, 15) == 0);
            rd_addr = 2'($urandom);
            step("R2");
        end
        for (int a = 0; a < 3; a++) rd(a, "R2");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule